// File: doc/BRIEF.md
# Packet Read Transfer Engine

This block hands the response to a read-type packet command from a device-side buffer to the host. A command decoder starts it with three values: the total byte length, the size of one PIO block, and a feature byte. Bit 0 of the feature byte selects the transfer mode.

In PIO mode the host pulls one 16-bit word per data-register read. The engine echoes the length into the byte-count registers. It pulses the interrupt at the start of the transfer, each time a block of the programmed size has been consumed, and at the end.

In DMA mode the host issues burst requests, each carrying a requested length. The engine clips each request to the bytes that remain and reports the clipped count. It then streams that many bytes, one per cycle. The last byte of the transfer comes with a completion interrupt and a separate DMA-done pulse.

The buffer sits outside the block and is reached through a synchronous RAM read port. That port has one cycle of read latency and is 16 bits wide. The byte at an even address sits in bits [7:0] and the next byte in bits [15:8].

Top module: `atr_engine`

## Requirements
- R1: After synchronous reset, status, interrupt reason and byte count are 0x00. irq, dma_done, dma_busy, dma_ack and pio_rvalid are all low.
- R2: A start with feature bit 0 clear enters PIO mode. On the clock after start, status is 0x58 and interrupt reason is 0x02. byte_count carries the latched length (low byte and high byte), and irq pulses for exactly one cycle.
- R3: A start with feature bit 0 set enters DMA mode. Status becomes 0xD0 and interrupt reason becomes 0x02. No interrupt is raised, and byte_count keeps its previous value. Feature bits other than bit 0 have no effect on the mode.
- R4: A PIO data read in PIO mode returns the word at the current byte offset, with pio_rvalid high, on the cycle after the strobe. The byte at the offset sits in bits [7:0] and the following byte in bits [15:8]. Each read advances the offset by 2.
- R5: Each PIO read subtracts 2 from a block countdown that start loads with the block size. When the countdown drops to 0 or below and the transfer is not finished, it reloads and irq pulses once, while status stays 0x58 and reason stays 0x02.
- R6: When a PIO read brings the offset to or past the length, the engine goes idle. Status becomes 0x50 (bit 3, DRQ, cleared), reason becomes 0x03 and irq pulses once. This holds even when the block countdown also runs out on that same read.
- R7: A PIO data read while not in PIO mode returns 0xFFFF with pio_rvalid high. It raises no interrupt and leaves status and reason unchanged.
- R8: A DMA request is answered one cycle later by a one-cycle dma_ack with dma_moved = min(requested, remaining). Outside DMA mode dma_moved is 0, and a zero count starts no burst.
- R9: An accepted burst keeps dma_busy high for exactly dma_moved sampled cycles, starting with the acknowledge cycle. During the burst, dma_bvalid presents consecutive buffer bytes from the current offset, one per cycle, with status 0xD0.
- R10: When the last byte of a DMA transfer is presented, the same cycle shows status 0x50 and reason 0x03, with irq and dma_done each pulsing for one cycle. The engine is then idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new transfer (one-cycle pulse) |
| start_len | input | LEN_W | Total byte length of the response |
| start_blk | input | LEN_W | PIO block size in bytes |
| start_feat | input | 8 | Feature byte; bit 0 selects DMA |
| pio_rd | input | 1 | Host data-register read strobe |
| pio_rvalid | output | 1 | Read data valid, one cycle after pio_rd |
| pio_rdata | output | 16 | Read word, or 0xFFFF outside PIO mode |
| dma_req | input | 1 | DMA burst request strobe |
| dma_req_len | input | LEN_W | Requested burst length in bytes |
| dma_ack | output | 1 | Burst request answered |
| dma_moved | output | LEN_W | Bytes the burst will move |
| dma_busy | output | 1 | Burst in progress |
| dma_bvalid | output | 1 | DMA byte valid |
| dma_byte | output | 8 | DMA data byte |
| buf_ren | output | 1 | Buffer read enable |
| buf_raddr | output | LEN_W-1 | Buffer word address |
| buf_rdata | input | 16 | Buffer read data, one cycle after buf_ren |
| status | output | 8 | Device status register |
| intr_reason | output | 8 | Interrupt reason (count) register |
| byte_count | output | LEN_W | Byte-count register pair |
| irq | output | 1 | Device interrupt pulse |
| dma_done | output | 1 | DMA completion pulse |

## Verification
Two updates can land on the same PIO read: the block countdown running out and the offset reaching the length. The bench provokes this by making the length a whole multiple of the block size. It then checks that the final read gives a single irq pulse with status 0x50 and reason 0x03, and that irq is low again on the next cycle. On the DMA side, the last streamed byte and the completion pulses share one cycle. The bench checks this by sampling status, irq and dma_done on the cycle dma_bvalid shows the final byte.

// File: rtl/atr_pkg.sv
package atr_pkg;
  typedef enum logic [1:0] {XS_IDLE, XS_PIO, XS_DMA} xfer_state_e;
  localparam logic [7:0] ST_PIO_ACTIVE = 8'h58;
  localparam logic [7:0] ST_DMA_ACTIVE = 8'hD0;
  localparam logic [7:0] ST_COMPLETE   = 8'h50;
  localparam logic [7:0] ST_DRQ_MASK   = 8'h08;
  localparam logic [7:0] RSN_DATA_IN   = 8'h02;
  localparam logic [7:0] RSN_COMPLETE  = 8'h03;
endpackage

// File: rtl/atr_burst.sv
module atr_burst #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic             go,
  input  logic [LEN_W-1:0] go_len,
  output logic             busy,
  output logic             step
);
  logic [LEN_W-1:0] cnt_q;

  assign busy = (cnt_q != '0);
  assign step = busy;

  always_ff @(posedge clk) begin
    if (rst || abort) cnt_q <= '0;
    else if (go)      cnt_q <= go_len;
    else if (step)    cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/atr_lane.sv
module atr_lane (
  input  logic        clk,
  input  logic        rst,
  input  logic        pio_rd,
  input  logic        pio_take,
  input  logic        step,
  input  logic        sel,
  input  logic [15:0] buf_rdata,
  output logic        pio_rvalid,
  output logic [15:0] pio_rdata,
  output logic        dma_bvalid,
  output logic [7:0]  dma_byte
);
  localparam int NLANE = 2;
  logic [7:0] lane [NLANE];
  logic rd_q, ok_q, bv_q, sel_q;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane[g] = buf_rdata[8*g +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0; ok_q <= 1'b0; bv_q <= 1'b0; sel_q <= 1'b0;
    end else begin
      rd_q  <= pio_rd;
      ok_q  <= pio_take;
      bv_q  <= step;
      sel_q <= sel;
    end
  end

  assign pio_rvalid = rd_q;
  assign pio_rdata  = ok_q ? buf_rdata : 16'hFFFF;
  assign dma_bvalid = bv_q;
  assign dma_byte   = lane[sel_q];
endmodule

// File: rtl/atr_ctrl.sv
module atr_ctrl
  import atr_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] start_len,
  input  logic [LEN_W-1:0] start_blk,
  input  logic             start_dma,
  input  logic             pio_rd,
  input  logic             dma_req,
  input  logic [LEN_W-1:0] dma_req_len,
  input  logic             busy,
  input  logic             step,
  output logic             pio_take,
  output logic             dma_go,
  output logic [LEN_W-1:0] go_len,
  output logic [LEN_W:0]   off,
  output logic             ack,
  output logic [LEN_W-1:0] moved,
  output logic [7:0]       status,
  output logic [7:0]       reason,
  output logic [LEN_W-1:0] bcount,
  output logic             irq,
  output logic             done
);
  localparam int OFF_W = LEN_W + 1;

  xfer_state_e       state_q;
  logic [LEN_W-1:0]  len_q, blk_q;
  logic [OFF_W-1:0]  off_q, remaining, req_ext, clip, len_ext, off_p1, off_p2;
  logic [OFF_W-1:0]  left_q, left_m2;
  logic              accept;

  assign len_ext   = {1'b0, len_q};
  assign req_ext   = {1'b0, dma_req_len};
  assign remaining = len_ext - off_q;
  assign clip      = (state_q != XS_DMA) ? '0 :
                     (req_ext < remaining) ? req_ext : remaining;
  assign off_p1    = off_q + 1'b1;
  assign off_p2    = off_q + 2'd2;
  assign left_m2   = left_q - 2'd2;
  assign accept    = dma_req && !busy && !start;
  assign pio_take  = pio_rd && (state_q == XS_PIO) && !start;
  assign dma_go    = accept && (clip != '0);
  assign go_len    = clip[LEN_W-1:0];
  assign off       = off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= XS_IDLE;
      len_q <= '0; blk_q <= '0; off_q <= '0; left_q <= '0;
      status <= '0; reason <= '0; bcount <= '0;
      irq <= 1'b0; done <= 1'b0; ack <= 1'b0; moved <= '0;
    end else begin
      irq  <= 1'b0;
      done <= 1'b0;
      ack  <= 1'b0;
      if (start) begin
        len_q  <= start_len;
        off_q  <= '0;
        reason <= RSN_DATA_IN;
        if (start_dma) begin
          state_q <= XS_DMA;
          status  <= ST_DMA_ACTIVE;
        end else begin
          state_q <= XS_PIO;
          status  <= ST_PIO_ACTIVE;
          bcount  <= start_len;
          blk_q   <= start_blk;
          left_q  <= {1'b0, start_blk};
          irq     <= 1'b1;
        end
      end else begin
        if (pio_take) begin
          off_q <= off_p2;
          if (off_p2 >= len_ext) begin
            state_q <= XS_IDLE;
            status  <= status & ~ST_DRQ_MASK;
            reason  <= RSN_COMPLETE;
            irq     <= 1'b1;
          end else if (left_m2[LEN_W] || left_m2 == '0) begin
            left_q <= {1'b0, blk_q};
            irq    <= 1'b1;
          end else begin
            left_q <= left_m2;
          end
        end
        if (step) begin
          off_q <= off_p1;
          if (off_p1 >= len_ext) begin
            state_q <= XS_IDLE;
            status  <= ST_COMPLETE;
            reason  <= RSN_COMPLETE;
            irq     <= 1'b1;
            done    <= 1'b1;
          end
        end
        if (accept) begin
          ack   <= 1'b1;
          moved <= clip[LEN_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/atr_engine.sv
module atr_engine #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] start_len,
  input  logic [LEN_W-1:0] start_blk,
  input  logic [7:0]       start_feat,
  input  logic             pio_rd,
  output logic             pio_rvalid,
  output logic [15:0]      pio_rdata,
  input  logic             dma_req,
  input  logic [LEN_W-1:0] dma_req_len,
  output logic             dma_ack,
  output logic [LEN_W-1:0] dma_moved,
  output logic             dma_busy,
  output logic             dma_bvalid,
  output logic [7:0]       dma_byte,
  output logic             buf_ren,
  output logic [LEN_W-2:0] buf_raddr,
  input  logic [15:0]      buf_rdata,
  output logic [7:0]       status,
  output logic [7:0]       intr_reason,
  output logic [LEN_W-1:0] byte_count,
  output logic             irq,
  output logic             dma_done
);
  logic             pio_take, dma_go, step;
  logic [LEN_W-1:0] go_len;
  logic [LEN_W:0]   off;

  atr_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .start_len(start_len),
    .start_blk(start_blk), .start_dma(start_feat[0]), .pio_rd(pio_rd),
    .dma_req(dma_req), .dma_req_len(dma_req_len), .busy(dma_busy),
    .step(step), .pio_take(pio_take), .dma_go(dma_go), .go_len(go_len),
    .off(off), .ack(dma_ack), .moved(dma_moved), .status(status),
    .reason(intr_reason), .bcount(byte_count), .irq(irq), .done(dma_done)
  );

  atr_burst #(.LEN_W(LEN_W)) u_burst (
    .clk(clk), .rst(rst), .abort(start), .go(dma_go), .go_len(go_len),
    .busy(dma_busy), .step(step)
  );

  atr_lane u_lane (
    .clk(clk), .rst(rst), .pio_rd(pio_rd), .pio_take(pio_take),
    .step(step), .sel(off[0]), .buf_rdata(buf_rdata),
    .pio_rvalid(pio_rvalid), .pio_rdata(pio_rdata),
    .dma_bvalid(dma_bvalid), .dma_byte(dma_byte)
  );

  assign buf_ren   = pio_take | step;
  assign buf_raddr = off[LEN_W-1:1];
endmodule

// File: rtl/atr_engine_chk.sv
module atr_engine_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             dma_done,
  input logic             dma_ack,
  input logic [LEN_W-1:0] dma_moved,
  input logic             dma_busy,
  input logic             dma_bvalid,
  input logic [7:0]       status,
  input logic [7:0]       intr_reason
);
  AST_DONE_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
    dma_done |-> irq && dma_bvalid);  // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    dma_done |=> !dma_done);  // R10
  AST_ZERO_NO_BURST: assert property (@(posedge clk) disable iff (rst)
    (dma_ack && dma_moved == '0) |-> !dma_busy);  // R8
  AST_ACK_STARTS_BURST: assert property (@(posedge clk) disable iff (rst)
    (dma_ack && dma_moved != '0) |-> dma_busy);  // R9
  AST_BYTE_FROM_BURST: assert property (@(posedge clk) disable iff (rst)
    dma_bvalid |-> $past(dma_busy));  // R9
  AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (rst)
    dma_busy |-> status == 8'hD0);  // R9
  AST_END_STATUS: assert property (@(posedge clk) disable iff (rst)
    (irq && intr_reason == 8'h03) |-> status == 8'h50);  // R6
endmodule

bind atr_engine atr_engine_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .dma_done(dma_done), .dma_ack(dma_ack),
  .dma_moved(dma_moved), .dma_busy(dma_busy), .dma_bvalid(dma_bvalid),
  .status(status), .intr_reason(intr_reason)
);

// File: tb/atr_engine_tb.sv
module atr_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, pio_rd = 0, dma_req = 0;
  logic [LEN_W-1:0] start_len = '0, start_blk = '0, dma_req_len = '0;
  logic [7:0] start_feat = '0;
  logic pio_rvalid, dma_ack, dma_busy, dma_bvalid, buf_ren, irq, dma_done;
  logic [15:0] pio_rdata, buf_rdata;
  logic [LEN_W-1:0] dma_moved, byte_count;
  logic [LEN_W-2:0] buf_raddr;
  logic [7:0] dma_byte, status, intr_reason;
  int n_chk = 0, n_bad = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atr_engine #(.LEN_W(LEN_W)) u_dut (.*);

  function automatic logic [7:0] bval(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  always_ff @(posedge clk)
    if (buf_ren) buf_rdata <= {bval(2*int'(buf_raddr)+1), bval(2*int'(buf_raddr))};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_start(int len, int blk, logic [7:0] feat);
    @(negedge clk);
    start = 1; start_len = LEN_W'(len); start_blk = LEN_W'(blk); start_feat = feat;
    @(negedge clk);
    start = 0;
  endtask

  // PIO transfer checked against a step-by-step model of R4..R6
  task automatic t_pio(int len, int blk);
    int off = 0, left = blk;
    do_start(len, blk, 8'h00);
    check("R2 status", status, 8'h58);
    check("R2 reason", intr_reason, 8'h02);
    check("R2 byte_count", byte_count, len);
    check("R2 irq", irq, 1);
    @(negedge clk);
    check("R2 irq one cycle", irq, 0);
    while (off < len) begin
      bit e_irq = 0, e_end = 0;
      int w = off;
      off += 2;
      if (off >= len) begin e_end = 1; e_irq = 1; end
      else begin
        left -= 2;
        if (left <= 0) begin left = blk; e_irq = 1; end
      end
      pio_rd = 1;
      @(negedge clk);
      pio_rd = 0;
      check("R4 rvalid", pio_rvalid, 1);
      check("R4 data", pio_rdata, {bval(w+1), bval(w)});
      check(e_end ? "R6 irq" : "R5 irq", irq, e_irq);
      check(e_end ? "R6 status" : "R5 status", status, e_end ? 8'h50 : 8'h58);
      check(e_end ? "R6 reason" : "R5 reason", intr_reason, e_end ? 8'h03 : 8'h02);
    end
    @(negedge clk);
    check("R6 single irq", irq, 0);
  endtask

  task automatic t_pio_idle();
    logic [7:0] s = status, r = intr_reason;
    @(negedge clk);
    pio_rd = 1;
    @(negedge clk);
    pio_rd = 0;
    check("R7 rvalid", pio_rvalid, 1);
    check("R7 data", pio_rdata, 16'hFFFF);
    check("R7 irq", irq, 0);
    check("R7 status", status, s);
    check("R7 reason", intr_reason, r);
  endtask

  task automatic t_dma(int req, int exp_moved, int first, bit exp_done);
    int got = 0, nbusy = 0;
    bit seen = 0;
    @(negedge clk);
    dma_req = 1; dma_req_len = LEN_W'(req);
    @(negedge clk);
    dma_req = 0;
    check("R8 ack", dma_ack, 1);
    check("R8 moved", dma_moved, exp_moved);
    if (dma_busy) nbusy++;
    for (int c = 0; c < exp_moved + 3; c++) begin
      @(negedge clk);
      check("R8 ack pulse", dma_ack, 0);
      if (dma_busy) nbusy++;
      if (dma_bvalid) begin
        check("R9 byte", dma_byte, bval(first + got));
        got++;
      end
      if (dma_done) begin
        seen = 1;
        check("R10 last byte", got, exp_moved);
        check("R10 status", status, 8'h50);
        check("R10 reason", intr_reason, 8'h03);
        check("R10 irq", irq, 1);
      end
    end
    check("R9 byte count", got, exp_moved);
    check("R9 busy cycles", nbusy, exp_moved);
    check("R10 done seen", seen, exp_done);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!ended) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 status", status, 0);
    check("R1 reason", intr_reason, 0);
    check("R1 byte_count", byte_count, 0);
    check("R1 quiet", {irq, dma_done, dma_busy, dma_ack, pio_rvalid}, 0);
    t_pio_idle();                    // R7 after reset
    t_pio(10, 4);                    // R5 boundaries then R6 end
    t_pio(8, 4);                     // R6 end coincides with block boundary
    t_pio(5, 2);                     // odd length, irq every word
    t_pio_idle();                    // R7 after completion
    // R3: DMA start, other feature bits ignored
    do_start(7, 4, 8'hA1);
    check("R3 status", status, 8'hD0);
    check("R3 reason", intr_reason, 8'h02);
    check("R3 irq", irq, 0);
    check("R3 byte_count kept", byte_count, 5);
    t_pio_idle();                    // R7 in DMA mode
    t_dma(0, 0, 0, 0);               // R8 zero request
    t_dma(3, 3, 0, 0);               // R9 partial burst
    t_dma(10, 4, 3, 1);              // R8 clipped, R10 completion
    t_dma(4, 0, 0, 0);               // R8 idle gives 0
    // R3: feature bit 0 clear with other bits set gives PIO
    do_start(4, 2, 8'hFE);
    check("R3 pio mode status", status, 8'h58);
    check("R3 pio mode irq", irq, 1);
    t_dma(2, 0, 0, 0);               // R8 no DMA in PIO mode
    ended = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule